// File: doc/BRIEF.md
# Direct Input Output Combiner

This block decides the final on/off command of four switched outputs. Each channel's command is built from two sources. One is a hardware input pin, which is often a single PWM signal shared by several channels. The other is the channel's bit in a separate output-control register that software writes. Per channel, software picks one of three ways to combine them:

- the pin OR the register bit;
- the pin AND the register bit;
- the register bit alone, with the pin ignored.

AND mode lets one shared PWM drive many channels while software can still force any one of them off.

Configuration arrives as decoded 16-bit words with a write strobe and an address. A write to the configuration address selects one channel through a two-bit field. It then replaces that channel's four settings: direct-disable, combine mode, sense-ratio select and slew select. The sense and slew flags are passed out for the analog side. The input pins are resynchronised by two flip-flops before they are combined.

Top module: `dinput_combiner`

## Requirements
- R1: A write with `wr_en` high and `wr_addr` equal to the configuration address (default 5'b00100) updates only the channel numbered by `wr_data[12:11]`. The other channels keep their settings.
- R2: When the channel's direct-disable bit (`wr_data[1]` = 1) is set, `chan_cmd` for that channel equals its `spi_on` bit, whatever the pin does.
- R3: When direct control is enabled (`wr_data[1]` = 0) and `wr_data[0]` = 1, `chan_cmd` is the AND of the synchronised pin and `spi_on`.
- R4: When direct control is enabled and `wr_data[0]` = 0, `chan_cmd` is the OR of the synchronised pin and `spi_on`.
- R5: `sense_hi` for a channel follows the `wr_data[2]` value last written to it; 1 selects the high ratio.
- R6: `slew_fast` for a channel follows the `wr_data[3]` value last written to it; 1 selects the fast rate.
- R7: After reset, every channel has direct control enabled and OR mode, and `sense_hi` and `slew_fast` are 0.
- R8: A write to any other address, or a word presented with `wr_en` low, changes no setting.
- R9: A pin change reaches `chan_cmd` after exactly two rising clock edges, not one. A change of `spi_on` or of a setting takes effect without that delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for a decoded word |
| wr_addr | input | 5 | Register address of the word |
| wr_data | input | 16 | Decoded word; [12:11] channel, [3:0] settings |
| spi_on | input | 4 | Per-channel on bits from the output-control register |
| pin_in | input | 4 | Asynchronous direct input pins |
| chan_cmd | output | 4 | Final on/off command per channel |
| sense_hi | output | 4 | High current-sense ratio select per channel |
| slew_fast | output | 4 | Fast slew select per channel |

## Verification
The bench targets the channel-select field, the address and strobe decode, the pin pipeline depth, and the reset defaults.

- **Channel select:** a design that decodes the field at the wrong bits, or updates every channel, shows mismatched settings on channels that were not addressed.
- **Decode:** a design that ignores the address or the strobe changes `sense_hi` or `chan_cmd` after a write that should have no effect.
- **Pipeline depth:** the bench checks the cycle between the first and second edge after a pin change. A design with one synchroniser stage, or three, is caught there.
- **Reset and modes:** a wrong reset mode makes the pins fail to turn channels on after reset. Swapped AND/OR handling gives the wrong command for a pin high with the register bit low.

// File: rtl/dinput_combiner.sv
module dinput_combiner #(
  parameter int NCH = 4,
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 5'b00100,
  parameter int SEL_LSB = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [NCH-1:0]    spi_on,
  input  logic [NCH-1:0]    pin_in,
  output logic [NCH-1:0]    chan_cmd,
  output logic [NCH-1:0]    sense_hi,
  output logic [NCH-1:0]    slew_fast
);
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] pin_s1, pin_s2;
  logic [NCH-1:0] dir_dis, and_mode, ratio_q, fast_q;
  logic           hit;
  logic [SEL_W-1:0] sel;
  logic           unused_bits;

  assign hit = wr_en && (wr_addr == CFG_ADDR);
  assign sel = wr_data[SEL_LSB +: SEL_W];
  assign unused_bits = ^{wr_data[15:SEL_LSB+SEL_W], wr_data[SEL_LSB-1:4]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_s1 <= '0;
      pin_s2 <= '0;
    end else begin
      pin_s1 <= pin_in;
      pin_s2 <= pin_s1;
    end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        fast_q[i]   <= 1'b0;
        ratio_q[i]  <= 1'b0;
        dir_dis[i]  <= 1'b0;
        and_mode[i] <= 1'b0;
      end else if (hit && sel == SEL_W'(i)) begin
        fast_q[i]   <= wr_data[3];
        ratio_q[i]  <= wr_data[2];
        dir_dis[i]  <= wr_data[1];
        and_mode[i] <= wr_data[0];
      end

    assign chan_cmd[i] = dir_dis[i]  ? spi_on[i] :
                         and_mode[i] ? (pin_s2[i] & spi_on[i]) :
                                       (pin_s2[i] | spi_on[i]);
  end

  assign sense_hi  = ratio_q;
  assign slew_fast = fast_q;

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    a_r8_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> ($stable(sense_hi[i]) && $stable(slew_fast[i])));
    a_r1_other_chan_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && sel != SEL_W'(i)) |=> ($stable(sense_hi[i]) && $stable(slew_fast[i])));
    a_r5_ratio_written: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && sel == SEL_W'(i)) |=> (sense_hi[i] == $past(wr_data[2])));
    a_r3_and_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_dis[i] && and_mode[i] && !spi_on[i]) |-> !chan_cmd[i]);
    a_r4_or_forces_on: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_dis[i] && !and_mode[i] && spi_on[i]) |-> chan_cmd[i]);
    a_r9_two_stage_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && !dir_dis[i] && !and_mode[i] && !spi_on[i])
        |-> (chan_cmd[i] == $past(pin_in[i], 2)));
  end
endmodule

// File: tb/tb_dinput_combiner.sv
module tb_dinput_combiner;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0] spi_on = '0;
  logic [3:0] pin_in = '0;
  logic [3:0] chan_cmd, sense_hi, slew_fast;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [3:0] mdl [4];

  always #5 clk = ~clk;

  dinput_combiner dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .spi_on(spi_on), .pin_in(pin_in), .chan_cmd(chan_cmd),
    .sense_hi(sense_hi), .slew_fast(slew_fast));

  // {channel, d3..d0, pin, spi}
  localparam logic [7:0] VEC [12] = '{
    {2'd0, 4'b0000, 1'b1, 1'b0},
    {2'd0, 4'b0000, 1'b0, 1'b0},
    {2'd1, 4'b0001, 1'b1, 1'b0},
    {2'd1, 4'b0001, 1'b1, 1'b1},
    {2'd2, 4'b0010, 1'b1, 1'b0},
    {2'd2, 4'b0010, 1'b0, 1'b1},
    {2'd3, 4'b0101, 1'b0, 1'b1},
    {2'd3, 4'b1100, 1'b0, 1'b1},
    {2'd0, 4'b1011, 1'b1, 1'b0},
    {2'd1, 4'b0100, 1'b0, 1'b1},
    {2'd2, 4'b0001, 1'b0, 1'b0},
    {2'd3, 4'b0011, 1'b1, 1'b1}
  };

  function automatic logic [3:0] exp_cmd(logic [3:0] pins, logic [3:0] spi);
    logic [3:0] r;
    for (int i = 0; i < 4; i++)
      r[i] = mdl[i][1] ? spi[i] : mdl[i][0] ? (pins[i] & spi[i]) : (pins[i] | spi[i]);
    return r;
  endfunction

  function automatic logic [3:0] exp_bit(int b);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = mdl[i][b];
    return r;
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic write(logic [4:0] addr, logic en, logic [1:0] ch, logic [3:0] d);
    @(negedge clk);
    wr_en = en;
    wr_addr = addr;
    wr_data = {3'b000, ch, 7'b0, d};
    @(negedge clk);
    wr_en = 1'b0;
    if (en && addr == 5'b00100) mdl[ch] = d;
  endtask

  task automatic reset_model();
    for (int i = 0; i < 4; i++) mdl[i] = 4'b0000;
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    reset_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 sense reset", sense_hi, 4'b0000);
    chk("R7 slew reset", slew_fast, 4'b0000);
    pin_in = 4'b1111;
    repeat (2) @(negedge clk);
    chk("R7 default OR direct", chan_cmd, 4'b1111);

    for (int v = 0; v < 12; v++) begin
      logic [1:0] ch;
      logic [3:0] d;
      ch = VEC[v][7:6];
      d = VEC[v][5:2];
      pin_in = {4{VEC[v][1]}};
      spi_on = {4{VEC[v][0]}};
      write(5'b00100, 1'b1, ch, d);
      repeat (2) @(negedge clk);
      chk(d[1] ? "R2 pin ignored" : (d[0] ? "R3 AND mode" : "R4 OR mode"),
          chan_cmd, exp_cmd(pin_in, spi_on));
      chk("R5 sense select", sense_hi, exp_bit(2));
      chk("R6 slew select", slew_fast, exp_bit(3));
    end

    write(5'b00100, 1'b1, 2'd2, 4'b1110);
    chk("R1 only selected ratio", sense_hi, exp_bit(2));
    chk("R1 only selected slew", slew_fast, exp_bit(3));
    write(5'b00100, 1'b1, 2'd1, 4'b1011);
    chk("R1 only selected ratio 2", sense_hi, exp_bit(2));

    write(5'b00101, 1'b1, 2'd0, 4'b0100);
    chk("R8 wrong address sense", sense_hi, exp_bit(2));
    write(5'b00100, 1'b0, 2'd3, 4'b1110);
    chk("R8 strobe low slew", slew_fast, exp_bit(3));
    pin_in = 4'b1010;
    spi_on = 4'b0101;
    repeat (2) @(negedge clk);
    chk("R8 commands unchanged", chan_cmd, exp_cmd(pin_in, spi_on));

    write(5'b00100, 1'b1, 2'd0, 4'b0000);
    pin_in = 4'b0000;
    spi_on = 4'b0000;
    repeat (3) @(negedge clk);
    chk("R9 settled low", chan_cmd, 4'b0000);
    pin_in[0] = 1'b1;
    @(negedge clk);
    chk("R9 not after one edge", chan_cmd, 4'b0000);
    @(negedge clk);
    chk("R9 after two edges", chan_cmd, 4'b0001);
    spi_on[2] = 1'b1;
    #1;
    chk("R9 spi immediate", chan_cmd, exp_cmd(pin_in, spi_on));

    @(negedge clk);
    rst_n = 1'b0;
    reset_model();
    @(negedge clk);
    rst_n = 1'b1;
    pin_in = 4'b0000;
    spi_on = 4'b1001;
    @(negedge clk);
    chk("R7 reset clears sense", sense_hi, 4'b0000);
    chk("R7 reset clears slew", slew_fast, 4'b0000);
    chk("R7 reset OR with spi", chan_cmd, 4'b1001);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule